// File: doc/BRIEF.md
# Configuration Test Access Port

This block is a serial configuration port built on the four-wire test access protocol of IEEE 1149.1. A host drives `tck`, `tms` and `tdi`, reads `tdo`, and through a fixed instruction map reaches a set of data registers that hold the chip's configuration. Each configuration register has a shift stage and a separate update stage. The shift stage loads the register's present contents when captured and is exchanged serially with the host. The update stage drives the register's value in parallel to the rest of the chip and changes only when a scan completes.

The controller has sixteen states: Test-Logic-Reset (`TS_RESET`), Run-Test/Idle (`TS_IDLE`), and two parallel branches. The data branch is `TS_DR_SCAN`, `TS_DR_CAPTURE`, `TS_DR_SHIFT`, `TS_DR_EXIT1`, `TS_DR_PAUSE`, `TS_DR_EXIT2` and `TS_DR_UPDATE`. The instruction branch has the same seven steps with `IR` in place of `DR`. With TMS high the transitions are: reset to reset, idle to DR scan, DR scan to IR scan, IR scan to reset, capture to exit1, shift to exit1, exit1 to update, pause to exit2, exit2 to update, and update to DR scan. With TMS low the transitions are: reset to idle, idle to idle, each scan state to its capture, capture to shift, shift to shift, exit1 to pause, pause to pause, exit2 to shift, and update to idle.

The two line-pattern registers reserve their upper `TAG_W` bits for a frame counter value supplied from outside. Those bits are read-only. Parameters set every register width, so the line-wide registers can be built narrow for simulation.

Top module: `cfg_tap_top`

## Requirements
- R1: The controller follows the sixteen-state TMS transition graph above. Five consecutive rising `tck` edges with `tms` high reach `TS_RESET` from any state.
- R2: While `trst_n` is low, or whenever the controller is in `TS_RESET`, the instruction becomes 0x0E. Asserting `trst_n` low also clears every parallel configuration output to zero.
- R3: Capturing the instruction register loads bits [1:0] with binary 01 and bits [4:2] with bits [4:2] of the current instruction. The instruction changes only in `TS_IR_UPDATE` or `TS_RESET`.
- R4: Instruction 0x0E selects a 32-bit read-only identification register that reads 0x50483101.
- R5: Instruction codes select data registers as follows: 0x0F selects a 128-bit bias register, 0x12 a 128-bit sequencer register, 0x13 a 40-bit control register, 0x1E and 0x1D two 8-bit mode registers (mode0, mode1), 0x11 a `LINE_W`-bit column-disable register, and 0x10 and 0x14 the two `LINE_W`-bit line-pattern registers (pattern0, pattern1).
- R6: Codes 0x02, 0x04, 0x1F, the reserved codes 0x15 to 0x1B and every code not listed in R4, R5 or R7 select a one-bit bypass stage that captures 0.
- R7: Codes 0x01, 0x03 and 0x05 select a 10-bit boundary-scan shift register.
- R8: Every register shifts least significant bit first. During a write, the bits that appear on `tdo` are the value the register held before the write.
- R9: A parallel output changes only on the rising edge that leaves `TS_DR_UPDATE`, and only for the register the current instruction selects. Outputs stay stable during shifting.
- R10: In a line-pattern register, capture places `frame_tag` in the top `TAG_W` bits. Writes to those bits are ignored. The parallel output carries only the lower `LINE_W-TAG_W` bits.
- R11: `tdo` and `tdo_en` change on the falling edge of `tck`. `tdo_en` is high only in `TS_DR_SHIFT` or `TS_IR_SHIFT`, and `tdo` is held at 0 whenever `tdo_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low reset |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in, sampled on the rising edge |
| frame_tag | input | TAG_W | Frame counter value captured into the pattern registers' top bits |
| tdo | output | 1 | Serial data out, changes on the falling edge |
| tdo_en | output | 1 | High while `tdo` carries shift data |
| bias_q | output | BIAS_W | Bias register parallel value |
| seq_q | output | SEQ_W | Sequencer register parallel value |
| ctrl_q | output | CTRL_W | Control register parallel value |
| mode0_q | output | MODE_W | Mode register 0 parallel value |
| mode1_q | output | MODE_W | Mode register 1 parallel value |
| coldis_q | output | LINE_W | Column-disable register parallel value |
| pat0_q | output | LINE_W-TAG_W | Line-pattern register 0 writable bits |
| pat1_q | output | LINE_W-TAG_W | Line-pattern register 1 writable bits |

## Verification
On every cycle the assertions check these properties: the return to `TS_RESET` after five TMS-high edges, the reload of the identification opcode in that state, the instruction and parallel outputs holding between update states, and `tdo` staying idle outside the shift states. Only the bench's scenarios can show the decoded register length for each code, the identification value, the read-before-write order of the shifted bits, the frame tag in the pattern registers, and the half-cycle offset of `tdo` relative to the rising edge.

// File: rtl/cfg_tap_pkg.sv
package cfg_tap_pkg;

    typedef enum logic [3:0] {
        TS_RESET, TS_IDLE,
        TS_DR_SCAN, TS_DR_CAPTURE, TS_DR_SHIFT, TS_DR_EXIT1,
        TS_DR_PAUSE, TS_DR_EXIT2, TS_DR_UPDATE,
        TS_IR_SCAN, TS_IR_CAPTURE, TS_IR_SHIFT, TS_IR_EXIT1,
        TS_IR_PAUSE, TS_IR_EXIT2, TS_IR_UPDATE
    } tap_state_t;

    typedef enum logic [3:0] {
        DSEL_BYPASS, DSEL_IDENT, DSEL_BSCAN, DSEL_BIAS, DSEL_PAT0,
        DSEL_COLDIS, DSEL_SEQ, DSEL_CTRL, DSEL_PAT1, DSEL_MODE1, DSEL_MODE0
    } dsel_t;

    localparam int          IR_W        = 5;
    localparam int          IDENT_W     = 32;
    localparam logic [31:0] IDENT_VALUE = 32'h5048_3101;

    localparam logic [IR_W-1:0] OP_BSCAN_A = 5'h01;
    localparam logic [IR_W-1:0] OP_BYP_A   = 5'h02;
    localparam logic [IR_W-1:0] OP_BSCAN_B = 5'h03;
    localparam logic [IR_W-1:0] OP_BYP_B   = 5'h04;
    localparam logic [IR_W-1:0] OP_BSCAN_C = 5'h05;
    localparam logic [IR_W-1:0] OP_IDCODE  = 5'h0E;
    localparam logic [IR_W-1:0] OP_BIAS    = 5'h0F;
    localparam logic [IR_W-1:0] OP_PAT0    = 5'h10;
    localparam logic [IR_W-1:0] OP_COLDIS  = 5'h11;
    localparam logic [IR_W-1:0] OP_SEQ     = 5'h12;
    localparam logic [IR_W-1:0] OP_CTRL    = 5'h13;
    localparam logic [IR_W-1:0] OP_PAT1    = 5'h14;
    localparam logic [IR_W-1:0] OP_MODE1   = 5'h1D;
    localparam logic [IR_W-1:0] OP_MODE0   = 5'h1E;
    localparam logic [IR_W-1:0] OP_BYP_C   = 5'h1F;

endpackage

// File: rtl/cfg_tap_fsm.sv
module cfg_tap_fsm
    import cfg_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_t state,
    output logic       in_reset,
    output logic       capture_dr,
    output logic       shift_dr,
    output logic       update_dr,
    output logic       capture_ir,
    output logic       shift_ir,
    output logic       update_ir
);

    tap_state_t state_nxt;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state <= TS_RESET;
        else         state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            TS_RESET:      state_nxt = tms ? TS_RESET     : TS_IDLE;
            TS_IDLE:       state_nxt = tms ? TS_DR_SCAN   : TS_IDLE;
            TS_DR_SCAN:    state_nxt = tms ? TS_IR_SCAN   : TS_DR_CAPTURE;
            TS_DR_CAPTURE: state_nxt = tms ? TS_DR_EXIT1  : TS_DR_SHIFT;
            TS_DR_SHIFT:   state_nxt = tms ? TS_DR_EXIT1  : TS_DR_SHIFT;
            TS_DR_EXIT1:   state_nxt = tms ? TS_DR_UPDATE : TS_DR_PAUSE;
            TS_DR_PAUSE:   state_nxt = tms ? TS_DR_EXIT2  : TS_DR_PAUSE;
            TS_DR_EXIT2:   state_nxt = tms ? TS_DR_UPDATE : TS_DR_SHIFT;
            TS_DR_UPDATE:  state_nxt = tms ? TS_DR_SCAN   : TS_IDLE;
            TS_IR_SCAN:    state_nxt = tms ? TS_RESET     : TS_IR_CAPTURE;
            TS_IR_CAPTURE: state_nxt = tms ? TS_IR_EXIT1  : TS_IR_SHIFT;
            TS_IR_SHIFT:   state_nxt = tms ? TS_IR_EXIT1  : TS_IR_SHIFT;
            TS_IR_EXIT1:   state_nxt = tms ? TS_IR_UPDATE : TS_IR_PAUSE;
            TS_IR_PAUSE:   state_nxt = tms ? TS_IR_EXIT2  : TS_IR_PAUSE;
            TS_IR_EXIT2:   state_nxt = tms ? TS_IR_UPDATE : TS_IR_SHIFT;
            TS_IR_UPDATE:  state_nxt = tms ? TS_DR_SCAN   : TS_IDLE;
        endcase
    end

    always_comb begin
        in_reset   = (state == TS_RESET);
        capture_dr = (state == TS_DR_CAPTURE);
        shift_dr   = (state == TS_DR_SHIFT);
        update_dr  = (state == TS_DR_UPDATE);
        capture_ir = (state == TS_IR_CAPTURE);
        shift_ir   = (state == TS_IR_SHIFT);
        update_ir  = (state == TS_IR_UPDATE);
    end

endmodule

// File: rtl/cfg_tap_ir.sv
module cfg_tap_ir
    import cfg_tap_pkg::*;
(
    input  logic            tck,
    input  logic            trst_n,
    input  logic            in_reset,
    input  logic            capture_ir,
    input  logic            shift_ir,
    input  logic            update_ir,
    input  logic            tdi,
    output logic [IR_W-1:0] ir_q,
    output logic            ir_so,
    output dsel_t           dsel
);

    logic [IR_W-1:0] ir_sr;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            ir_sr <= '0;
            ir_q  <= OP_IDCODE;
        end else begin
            if (in_reset)       ir_q <= OP_IDCODE;
            else if (update_ir) ir_q <= ir_sr;
            if (capture_ir)     ir_sr <= {ir_q[IR_W-1:2], 2'b01};
            else if (shift_ir)  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
        end
    end

    assign ir_so = ir_sr[0];

    always_comb begin
        unique case (ir_q)
            OP_BSCAN_A, OP_BSCAN_B, OP_BSCAN_C: dsel = DSEL_BSCAN;
            OP_IDCODE:                          dsel = DSEL_IDENT;
            OP_BIAS:                            dsel = DSEL_BIAS;
            OP_PAT0:                            dsel = DSEL_PAT0;
            OP_COLDIS:                          dsel = DSEL_COLDIS;
            OP_SEQ:                             dsel = DSEL_SEQ;
            OP_CTRL:                            dsel = DSEL_CTRL;
            OP_PAT1:                            dsel = DSEL_PAT1;
            OP_MODE1:                           dsel = DSEL_MODE1;
            OP_MODE0:                           dsel = DSEL_MODE0;
            default:                            dsel = DSEL_BYPASS;
        endcase
    end

endmodule

// File: rtl/cfg_tap_dreg.sv
module cfg_tap_dreg #(
    parameter int W    = 8,
    parameter int RO_W = 0,
    localparam int UW  = W - RO_W
) (
    input  logic          tck,
    input  logic          trst_n,
    input  logic          sel,
    input  logic          capture,
    input  logic          shift,
    input  logic          update,
    input  logic          tdi,
    input  logic [W-1:0]  cap_val,
    output logic          so,
    output logic [UW-1:0] upd_q
);

    logic [W-1:0] sr;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            sr    <= '0;
            upd_q <= '0;
        end else if (sel) begin
            if (capture)    sr <= cap_val;
            else if (shift) sr <= {tdi, sr[W-1:1]};
            if (update)     upd_q <= sr[UW-1:0];
        end
    end

    assign so = sr[0];

endmodule

// File: rtl/cfg_tap_top.sv
module cfg_tap_top
    import cfg_tap_pkg::*;
#(
    parameter int LINE_W = 640,
    parameter int TAG_W  = 10,
    parameter int BIAS_W = 128,
    parameter int SEQ_W  = 128,
    parameter int CTRL_W = 40,
    parameter int MODE_W = 8,
    parameter int BSR_W  = 10,
    localparam int PAT_UW = LINE_W - TAG_W
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tms,
    input  logic              tdi,
    input  logic [TAG_W-1:0]  frame_tag,
    output logic              tdo,
    output logic              tdo_en,
    output logic [BIAS_W-1:0] bias_q,
    output logic [SEQ_W-1:0]  seq_q,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [MODE_W-1:0] mode0_q,
    output logic [MODE_W-1:0] mode1_q,
    output logic [LINE_W-1:0] coldis_q,
    output logic [PAT_UW-1:0] pat0_q,
    output logic [PAT_UW-1:0] pat1_q
);

    tap_state_t      state;
    logic            in_reset, capture_dr, shift_dr, update_dr;
    logic            capture_ir, shift_ir, update_ir;
    logic [IR_W-1:0] ir_q;
    logic            ir_so;
    dsel_t           dsel;

    cfg_tap_fsm u_fsm (
        .tck(tck), .trst_n(trst_n), .tms(tms), .state(state),
        .in_reset(in_reset), .capture_dr(capture_dr), .shift_dr(shift_dr),
        .update_dr(update_dr), .capture_ir(capture_ir), .shift_ir(shift_ir),
        .update_ir(update_ir)
    );

    cfg_tap_ir u_ir (
        .tck(tck), .trst_n(trst_n), .in_reset(in_reset),
        .capture_ir(capture_ir), .shift_ir(shift_ir), .update_ir(update_ir),
        .tdi(tdi), .ir_q(ir_q), .ir_so(ir_so), .dsel(dsel)
    );

    // Identification and bypass stages: capture-only, no update stage.
    logic [IDENT_W-1:0] ident_sr;
    logic               byp_sr;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            ident_sr <= '0;
            byp_sr   <= 1'b0;
        end else begin
            if (dsel == DSEL_IDENT) begin
                if (capture_dr)    ident_sr <= IDENT_VALUE;
                else if (shift_dr) ident_sr <= {tdi, ident_sr[IDENT_W-1:1]};
            end
            if (dsel == DSEL_BYPASS) begin
                if (capture_dr)    byp_sr <= 1'b0;
                else if (shift_dr) byp_sr <= tdi;
            end
        end
    end

    // Configuration registers with capture of their own update value.
    logic bscan_so, bias_so, seq_so, ctrl_so, mode0_so, mode1_so, coldis_so;
    logic [BSR_W-1:0] bscan_q;

    cfg_tap_dreg #(.W(BSR_W)) u_bscan (
        .tck(tck), .trst_n(trst_n), .sel(dsel == DSEL_BSCAN),
        .capture(capture_dr), .shift(shift_dr), .update(update_dr), .tdi(tdi),
        .cap_val(bscan_q), .so(bscan_so), .upd_q(bscan_q)
    );

    cfg_tap_dreg #(.W(BIAS_W)) u_bias (
        .tck(tck), .trst_n(trst_n), .sel(dsel == DSEL_BIAS),
        .capture(capture_dr), .shift(shift_dr), .update(update_dr), .tdi(tdi),
        .cap_val(bias_q), .so(bias_so), .upd_q(bias_q)
    );

    cfg_tap_dreg #(.W(SEQ_W)) u_seq (
        .tck(tck), .trst_n(trst_n), .sel(dsel == DSEL_SEQ),
        .capture(capture_dr), .shift(shift_dr), .update(update_dr), .tdi(tdi),
        .cap_val(seq_q), .so(seq_so), .upd_q(seq_q)
    );

    cfg_tap_dreg #(.W(CTRL_W)) u_ctrl (
        .tck(tck), .trst_n(trst_n), .sel(dsel == DSEL_CTRL),
        .capture(capture_dr), .shift(shift_dr), .update(update_dr), .tdi(tdi),
        .cap_val(ctrl_q), .so(ctrl_so), .upd_q(ctrl_q)
    );

    cfg_tap_dreg #(.W(MODE_W)) u_mode0 (
        .tck(tck), .trst_n(trst_n), .sel(dsel == DSEL_MODE0),
        .capture(capture_dr), .shift(shift_dr), .update(update_dr), .tdi(tdi),
        .cap_val(mode0_q), .so(mode0_so), .upd_q(mode0_q)
    );

    cfg_tap_dreg #(.W(MODE_W)) u_mode1 (
        .tck(tck), .trst_n(trst_n), .sel(dsel == DSEL_MODE1),
        .capture(capture_dr), .shift(shift_dr), .update(update_dr), .tdi(tdi),
        .cap_val(mode1_q), .so(mode1_so), .upd_q(mode1_q)
    );

    cfg_tap_dreg #(.W(LINE_W)) u_coldis (
        .tck(tck), .trst_n(trst_n), .sel(dsel == DSEL_COLDIS),
        .capture(capture_dr), .shift(shift_dr), .update(update_dr), .tdi(tdi),
        .cap_val(coldis_q), .so(coldis_so), .upd_q(coldis_q)
    );

    // Two line-pattern registers: top TAG_W bits capture the frame tag.
    logic [PAT_UW-1:0] pat_q  [2];
    logic              pat_so [2];

    for (genvar gi = 0; gi < 2; gi++) begin : g_pat
        localparam dsel_t GSEL = (gi == 0) ? DSEL_PAT0 : DSEL_PAT1;
        cfg_tap_dreg #(.W(LINE_W), .RO_W(TAG_W)) u_pat (
            .tck(tck), .trst_n(trst_n), .sel(dsel == GSEL),
            .capture(capture_dr), .shift(shift_dr), .update(update_dr),
            .tdi(tdi), .cap_val({frame_tag, pat_q[gi]}),
            .so(pat_so[gi]), .upd_q(pat_q[gi])
        );
    end

    assign pat0_q = pat_q[0];
    assign pat1_q = pat_q[1];

    // Data-path output selection.
    logic dr_so;

    always_comb begin
        unique case (dsel)
            DSEL_IDENT:  dr_so = ident_sr[0];
            DSEL_BSCAN:  dr_so = bscan_so;
            DSEL_BIAS:   dr_so = bias_so;
            DSEL_PAT0:   dr_so = pat_so[0];
            DSEL_COLDIS: dr_so = coldis_so;
            DSEL_SEQ:    dr_so = seq_so;
            DSEL_CTRL:   dr_so = ctrl_so;
            DSEL_PAT1:   dr_so = pat_so[1];
            DSEL_MODE1:  dr_so = mode1_so;
            DSEL_MODE0:  dr_so = mode0_so;
            default:     dr_so = byp_sr;
        endcase
    end

    // Serial output retimed to the falling edge.
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo_en <= shift_ir | shift_dr;
            tdo    <= shift_ir ? ir_so : (shift_dr ? dr_so : 1'b0);
        end
    end

endmodule

// File: rtl/cfg_tap_chk.sv
module cfg_tap_chk
    import cfg_tap_pkg::*;
#(
    parameter int CTRL_W = 40,
    parameter int MODE_W = 8
) (
    input logic              tck,
    input logic              trst_n,
    input logic              tms,
    input tap_state_t        state,
    input logic [IR_W-1:0]   ir_q,
    input logic              tdo,
    input logic              tdo_en,
    input logic [MODE_W-1:0] mode0_q,
    input logic [CTRL_W-1:0] ctrl_q
);

    logic [2:0] since_rst;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)             since_rst <= '0;
        else if (since_rst != 7) since_rst <= since_rst + 3'd1;
    end

    AST_FIVE_HIGH_RESETS: assert property (@(posedge tck) disable iff (!trst_n)
        (since_rst >= 3'd4 && tms && $past(tms) && $past(tms, 2) && $past(tms, 3)
         && $past(tms, 4)) |=> state == TS_RESET); // R1

    AST_RESET_LOADS_IDCODE: assert property (@(posedge tck) disable iff (!trst_n)
        (state == TS_RESET) |=> (ir_q == OP_IDCODE)); // R2

    AST_IR_HOLDS: assert property (@(posedge tck) disable iff (!trst_n)
        (state != TS_IR_UPDATE && state != TS_RESET) |=> $stable(ir_q)); // R3

    AST_MODE_HOLDS: assert property (@(posedge tck) disable iff (!trst_n)
        (state != TS_DR_UPDATE) |=> $stable(mode0_q)); // R9

    AST_CTRL_HOLDS: assert property (@(posedge tck) disable iff (!trst_n)
        (state != TS_DR_UPDATE) |=> $stable(ctrl_q)); // R9

    AST_TDO_EN_SHIFT_ONLY: assert property (@(posedge tck) disable iff (!trst_n)
        (state != TS_DR_SHIFT && state != TS_IR_SHIFT) |-> !tdo_en); // R11

    AST_TDO_IDLE_LOW: assert property (@(posedge tck) disable iff (!trst_n)
        !tdo_en |-> !tdo); // R11

endmodule

bind cfg_tap_top cfg_tap_chk #(.CTRL_W(CTRL_W), .MODE_W(MODE_W)) u_chk (
    .tck(tck), .trst_n(trst_n), .tms(tms), .state(state), .ir_q(ir_q),
    .tdo(tdo), .tdo_en(tdo_en), .mode0_q(mode0_q), .ctrl_q(ctrl_q)
);

// File: tb/test_cfg_tap_top.sv
module test_cfg_tap_top;

    localparam int CLK_PERIOD = 10;
    localparam int LINE_W = 32;
    localparam int TAG_W  = 10;
    localparam int PAT_UW = LINE_W - TAG_W;
    localparam int MARK   = 180;
    localparam int NBITS  = 320;

    logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
    logic [TAG_W-1:0] frame_tag = '0;
    logic tdo, tdo_en;
    logic [127:0] bias_q, seq_q;
    logic [39:0]  ctrl_q;
    logic [7:0]   mode0_q, mode1_q;
    logic [LINE_W-1:0] coldis_q;
    logic [PAT_UW-1:0] pat0_q, pat1_q;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) tck = ~tck;

    cfg_tap_top #(.LINE_W(LINE_W), .TAG_W(TAG_W)) i_cfg_tap_top (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .frame_tag(frame_tag),
        .tdo(tdo), .tdo_en(tdo_en), .bias_q(bias_q), .seq_q(seq_q),
        .ctrl_q(ctrl_q), .mode0_q(mode0_q), .mode1_q(mode1_q),
        .coldis_q(coldis_q), .pat0_q(pat0_q), .pat1_q(pat1_q)
    );

    // {opcode, expected register length}
    localparam logic [15:0] DR_TABLE [20] = '{
        {8'h0E, 8'd32},  {8'h01, 8'd10},  {8'h03, 8'd10},  {8'h05, 8'd10},
        {8'h02, 8'd1},   {8'h04, 8'd1},   {8'h1F, 8'd1},   {8'h15, 8'd1},
        {8'h1B, 8'd1},   {8'h00, 8'd1},   {8'h0A, 8'd1},   {8'h1C, 8'd1},
        {8'h0F, 8'd128}, {8'h10, 8'd32},  {8'h14, 8'd32},  {8'h11, 8'd32},
        {8'h12, 8'd128}, {8'h13, 8'd40},  {8'h1D, 8'd8},   {8'h1E, 8'd8}
    };

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input logic m, input logic d, output logic o);
        o   = tdo;
        tms = m;
        tdi = d;
        @(posedge tck);
        @(negedge tck);
        #1;
    endtask

    task automatic shift_ir(input logic [4:0] code, output logic [4:0] cap);
        logic o;
        tick(1, 0, o); tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
        for (int i = 0; i < 5; i++) begin
            tick(i == 4, code[i], o);
            cap[i] = o;
        end
        tick(1, 0, o); tick(0, 0, o);
    endtask

    task automatic shift_dr(input int n, input logic [511:0] din, output logic [511:0] dout);
        logic o;
        dout = '0;
        tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
        for (int i = 0; i < n; i++) begin
            tick(i == n - 1, din[i], o);
            dout[i] = o;
        end
        tick(1, 0, o); tick(0, 0, o);
    endtask

    function automatic string tag_of(input logic [7:0] code);
        if (code == 8'h0E) return "R4";
        if (code == 8'h01 || code == 8'h03 || code == 8'h05) return "R7";
        if ((code >= 8'h0F && code <= 8'h14) || code == 8'h1D || code == 8'h1E) return "R5";
        return "R6";
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    initial begin
        repeat (150000) @(posedge tck);
        n_fails++;
        $display("FAIL R1 watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [4:0]   cap;
        logic [511:0] dout;
        logic         o;

        repeat (3) @(posedge tck);
        @(negedge tck);
        trst_n = 1'b1;
        #1;

        // R2: reset state of outputs
        check("R2 outputs after reset", {bias_q, mode0_q, mode1_q, ctrl_q[7:0]}, '0);
        check("R2 more outputs after reset", {seq_q[63:0], coldis_q, pat0_q, pat1_q}, '0);
        check("R11 idle tdo_en", {tdo_en, tdo}, 2'b00);
        tick(0, 0, o);

        // R2 / R4: identification selected after reset without loading IR
        shift_dr(32, '0, dout);
        check("R4 identification value", dout[31:0], 32'h5048_3101);

        // Table walk: register length selected by each code
        foreach (DR_TABLE[k]) begin
            logic [511:0] din;
            int found;
            din = '0;
            din[MARK] = 1'b1;
            shift_ir(DR_TABLE[k][12:8], cap);
            shift_dr(NBITS, din, dout);
            found = -1;
            for (int i = NBITS - 1; i >= MARK; i--) if (dout[i]) found = i - MARK;
            check($sformatf("%s length of code %h", tag_of(DR_TABLE[k][15:8]), DR_TABLE[k][15:8]),
                  128'(found), 128'(DR_TABLE[k][7:0]));
        end

        // R3: IR capture marker and upper instruction bits
        shift_ir(5'h13, cap);
        shift_ir(5'h1E, cap);
        check("R3 IR capture", cap, 5'h11);

        // R8 / R9: read-before-write on mode0, other outputs untouched
        shift_dr(8, 512'hA5, dout);
        check("R9 mode0 updated", mode0_q, 8'hA5);
        shift_dr(8, 512'h3C, dout);
        check("R8 previous mode0 on tdo", dout[7:0], 8'hA5);
        check("R9 mode0 second update", mode0_q, 8'h3C);
        check("R9 mode1 untouched", mode1_q, 8'h00);

        // R8: wide register read-before-write
        shift_ir(5'h0F, cap);
        shift_dr(128, 512'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, dout);
        check("R9 bias updated", bias_q, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210);
        shift_dr(128, '0, dout);
        check("R8 previous bias on tdo", dout[127:0], 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210);

        // R5 / R9: control register
        shift_ir(5'h13, cap);
        shift_dr(40, 512'h12_3456_789A, dout);
        check("R5 ctrl updated", ctrl_q, 40'h12_3456_789A);
        check("R9 mode0 held across ctrl write", mode0_q, 8'h3C);

        // R10: frame tag in pattern register top bits
        frame_tag = 10'h2C5;
        shift_ir(5'h14, cap);
        shift_dr(32, 512'hFFFF_F0F0, dout);
        check("R10 pattern1 writable bits", pat1_q, 22'h3FF0F0);
        shift_dr(32, '0, dout);
        check("R10 pattern1 capture with tag", dout[31:0], {10'h2C5, 22'h3FF0F0});
        check("R10 pattern0 untouched", pat0_q, 22'h0);

        // R11: tdo changes on the falling edge
        shift_ir(5'h0E, cap);
        tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
        check("R11 tdo_en in shift", {tdo_en, tdo}, 2'b11);
        tms = 0; tdi = 0;
        @(posedge tck); #1;
        check("R11 tdo held after rising edge", tdo, 1'b1);
        @(negedge tck); #1;
        check("R11 tdo moves on falling edge", tdo, 1'b0);
        tick(1, 0, o); tick(1, 0, o); tick(0, 0, o);
        check("R11 tdo idle in run-test", {tdo_en, tdo}, 2'b00);

        // R1: five TMS-high edges from Shift-DR return to reset
        shift_ir(5'h1D, cap);
        tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
        for (int i = 0; i < 5; i++) tick(1, 0, o);
        tick(0, 0, o);
        shift_dr(32, '0, dout);
        check("R1 reset reached, identification selected", dout[31:0], 32'h5048_3101);

        // R2: asynchronous reset clears configuration
        trst_n = 1'b0;
        #2;
        check("R2 clear on reset", {mode0_q, ctrl_q, bias_q[15:0]}, '0);
        @(negedge tck);
        trst_n = 1'b1;
        #1;
        tick(0, 0, o);
        shift_dr(32, '0, dout);
        check("R2 identification after reset", dout[31:0], 32'h5048_3101);

        summary();
        $finish;
    end

endmodule